// File: doc/BRIEF.md
# Sticky-Pending Interrupt Aggregator

This block gathers 32 level-sensitive interrupt request lines into a single interrupt output for a processor. Each line is registered into a live-state word. A sticky pending word collects every line seen high and keeps it until software clears it. A mask word selects which pending sources may drive the output. The output is high while any source is both pending and enabled.

Software uses a plain strobe register port. It can write the mask, and it can acknowledge pending bits by writing ones to the pending address. Every update ORs the current request levels back into pending, so acknowledging a line that is still high does not clear it. The port also reads the mask, pending and live words and a free-running assertion counter for each source. A counter advances on each low-to-high transition of its line.

All inputs are synchronous to the block clock. Reset is synchronous and active high.

Top module: `irq_pend_ctrl`

## Requirements
- R1: The live word, read at address 2, holds the level of each request line (bit n for line n) as sampled at the previous clock edge.
- R2: A pending bit is set by a clock edge at which its line is high. It stays set after the line falls, until software acknowledges it.
- R3: `irq_out` is registered. After each clock edge it is high exactly when the new pending word AND the new mask word is nonzero.
- R4: A write to address 0 replaces all 32 mask bits at once. The new mask reads back from address 0 and takes effect on `irq_out` at the same edge.
- R5: A write to address 1 clears every pending bit written as 1 whose line is low. Bits written as 0 keep their value.
- R6: A pending bit whose line is high at the acknowledge edge stays set. This includes a line that rises in the same cycle as its acknowledge.
- R7: The counter of source n, read at address 32+n, increments by one on each 0-to-1 transition of line n. It does not advance while the line stays high, and it wraps modulo 2^CNT_W.
- R8: A read strobe returns the addressed word on `rd_data` one cycle later. `rd_data` holds its value in cycles without a read strobe. Addresses 3 to 31 read as zero. Writes to address 2 and to the counter addresses have no effect.
- R9: Reset clears the mask, pending, live words, all counters, `irq_out` and `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level request lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the same cycle as a fresh rise of that same line. Random stimulus seldom lines up a write to address 1 with a new edge on the acknowledged bit. A directed step drives both in one cycle and then reads pending back. Counter wrap cannot be reached with 32-bit counters in a short run. The bench therefore adds a second instance with 3-bit counters on the same inputs and pulses one line past the wrap point.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_MASK = 0;
  localparam int unsigned REG_PEND = 1;
  localparam int unsigned REG_LIVE = 2;
endpackage

// File: rtl/irq_src_counter.sv
module irq_src_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  // R7: one step per rise, wraps naturally
  a_r7_count_step: assert property (@(posedge clk) disable iff (rst || !past_valid)
    inc |=> (cnt == $past(cnt) + 1'b1));
  a_r7_count_hold: assert property (@(posedge clk) disable iff (rst || !past_valid)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic [NUM_SRC-1:0] ack_vec,
  output logic [NUM_SRC-1:0] live_q,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] rise,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] pend_nxt, mask_nxt;

  always_comb begin
    mask_nxt = mask_we ? mask_wdata : mask_q;
    pend_nxt = (pend_q & ~ack_vec) | irq_in;
    rise     = irq_in & ~live_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      pend_q  <= '0;
      mask_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      live_q  <= irq_in;
      pend_q  <= pend_nxt;
      mask_q  <= mask_nxt;
      irq_out <= |(pend_nxt & mask_nxt);
    end
  end

  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  // R2: a pending bit only drops when it was acknowledged
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst || !past_valid)
    1'b1 |=> ((($past(pend_q) & ~$past(ack_vec)) & ~pend_q) == '0));
  // R6: a line seen high is always pending afterwards
  a_r6_live_pending: assert property (@(posedge clk) disable iff (rst || !past_valid)
    (live_q & ~pend_q) == '0);
  // R9: reset clears state
  a_r9_reset_clear: assert property (@(posedge clk)
    (past_valid && $past(rst)) |-> (pend_q == '0 && mask_q == '0 && live_q == '0 && !irq_out));
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_out
);
  import irq_pkg::*;

  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  localparam int unsigned CNT_SEL = ADDR_W - 1;

  logic [NUM_SRC-1:0] live_q, pend_q, mask_q, rise, ack_vec;
  logic               mask_we;
  logic [CNT_W-1:0]   cnt_q [NUM_SRC];
  logic [DATA_W-1:0]  rd_sel;

  assign mask_we = wr_en && (addr == ADDR_W'(REG_MASK));
  assign ack_vec = (wr_en && (addr == ADDR_W'(REG_PEND))) ? wr_data[NUM_SRC-1:0] : '0;

  irq_pend_core #(.NUM_SRC(NUM_SRC)) u_core (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .mask_we(mask_we), .mask_wdata(wr_data[NUM_SRC-1:0]), .ack_vec(ack_vec),
    .live_q(live_q), .pend_q(pend_q), .mask_q(mask_q), .rise(rise),
    .irq_out(irq_out)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cnt
    irq_src_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(rise[g]), .cnt(cnt_q[g])
    );
  end

  always_comb begin
    if (addr[CNT_SEL]) begin
      rd_sel = DATA_W'(cnt_q[addr[IDX_W-1:0]]);
    end else begin
      case (addr)
        ADDR_W'(REG_MASK): rd_sel = DATA_W'(mask_q);
        ADDR_W'(REG_PEND): rd_sel = DATA_W'(pend_q);
        ADDR_W'(REG_LIVE): rd_sel = DATA_W'(live_q);
        default:           rd_sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel;
  end

  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  // R3: output agrees with registered pending and mask
  a_r3_out_match: assert property (@(posedge clk) disable iff (rst || !past_valid)
    irq_out == |(pend_q & mask_q));
  // R5: acknowledged bits whose line was low are cleared
  a_r5_ack_clear: assert property (@(posedge clk) disable iff (rst || !past_valid)
    (wr_en && addr == ADDR_W'(REG_PEND)) |=>
      ((pend_q & $past(wr_data[NUM_SRC-1:0]) & ~$past(irq_in)) == '0));
  // R4: mask write lands in full
  a_r4_mask_load: assert property (@(posedge clk) disable iff (rst || !past_valid)
    (wr_en && addr == ADDR_W'(REG_MASK)) |=> (mask_q == $past(wr_data[NUM_SRC-1:0])));
  // R8: read data holds without a strobe
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (rst || !past_valid)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_irq_pend_ctrl.sv
module tb_irq_pend_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] irq_in;
  logic        wr_en, rd_en;
  logic [5:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data, rd_data_w;
  logic        irq_out, irq_out_w;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  irq_pend_ctrl #(.CNT_W(3)) dut_w (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data_w), .irq_out(irq_out_w)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] m_mask, m_pend, m_live, m_rd;
  logic [31:0] m_cnt [32];
  logic        m_out;

  function automatic logic [31:0] model_read(input logic [5:0] a);
    if (a == 6'd0)      return m_mask;
    else if (a == 6'd1) return m_pend;
    else if (a == 6'd2) return m_live;
    else if (a[5])      return m_cnt[a[4:0]];
    else                return 32'd0;
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    if (a == 6'd0)      return "R4";
    else if (a == 6'd1) return "R2";
    else if (a == 6'd2) return "R1";
    else if (a[5])      return "R7";
    else                return "R8";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mask = '0; m_pend = '0; m_live = '0; m_rd = '0; m_out = 1'b0;
    for (int i = 0; i < 32; i++) m_cnt[i] = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_in = '0; wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // One clock: drive at negedge, update model, compare at next negedge
  task automatic cyc(input logic [31:0] irq, input logic we, input logic re,
                     input logic [5:0] a, input logic [31:0] d, input string tag);
    logic [31:0] ack, mnext, rise, exp_rd;
    string t;
    irq_in = irq; wr_en = we; rd_en = re; addr = a; wr_data = d;
    ack   = (we && a == 6'd1) ? d : 32'd0;
    mnext = (we && a == 6'd0) ? d : m_mask;
    rise  = irq & ~m_live;
    exp_rd = re ? model_read(a) : m_rd;
    @(posedge clk);
    m_pend = (m_pend & ~ack) | irq;
    m_live = irq;
    m_mask = mnext;
    for (int i = 0; i < 32; i++) if (rise[i]) m_cnt[i] = m_cnt[i] + 1;
    m_out = |(m_pend & m_mask);
    m_rd  = exp_rd;
    @(negedge clk);
    check("R3", {31'd0, irq_out}, {31'd0, m_out});
    t = (tag != "") ? tag : (re ? tag_of(a) : "R8");
    check(t, rd_data, m_rd);
  endtask

  task automatic rd(input logic [31:0] irq, input logic [5:0] a, input string tag);
    cyc(irq, 1'b0, 1'b1, a, 32'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] irq;
    void'($urandom(32'd4242));
    do_reset();
    // R9: reset state
    check("R9", {31'd0, irq_out}, 32'd0);
    rd(32'd0, 6'd0, "R9");
    rd(32'd0, 6'd1, "R9");
    rd(32'd0, 6'd2, "R9");
    rd(32'd0, 6'd45, "R9");
    // R4: mask replace and readback
    cyc(32'd0, 1, 0, 6'd0, 32'hA5A5_0F0F, "R4");
    rd(32'd0, 6'd0, "R4");
    cyc(32'd0, 1, 0, 6'd0, 32'h0000_0F0F, "R4");
    // R2/R3: pulse line 3, then low; pending sticks, output rises
    cyc(32'h8, 0, 0, 6'd0, 0, "R2");
    check("R3", {31'd0, irq_out}, 32'd1);
    cyc(32'h0, 0, 0, 6'd0, 0, "R2");
    rd(32'h0, 6'd1, "R2");
    check("R2", rd_data, 32'h8);
    // R5: pend bits 3 and 8, ack only 3
    cyc(32'h100, 0, 0, 6'd0, 0, "R5");
    cyc(32'h0, 1, 0, 6'd1, 32'h8, "R5");
    rd(32'h0, 6'd1, "R5");
    check("R5", rd_data, 32'h100);
    check("R3", {31'd0, irq_out}, 32'd1);
    cyc(32'h0, 1, 0, 6'd1, 32'h100, "R5");
    check("R3", {31'd0, irq_out}, 32'd0);
    // R6: ack while line 5 held high; ack on rising edge of line 6
    cyc(32'h20, 0, 0, 6'd0, 0, "R6");
    cyc(32'h20, 1, 0, 6'd1, 32'h20, "R6");
    cyc(32'h60, 1, 0, 6'd1, 32'h40, "R6");
    rd(32'h60, 6'd1, "R6");
    check("R6", rd_data, 32'h60);
    // R1: live state
    rd(32'h60, 6'd2, "R1");
    check("R1", rd_data, 32'h60);
    // R7: held line counts once, pulses count each rise
    for (int i = 0; i < 4; i++) cyc(32'h60, 0, 0, 6'd0, 0, "R7");
    rd(32'h60, 6'd37, "R7");
    check("R7", rd_data, 32'd1);
    for (int i = 0; i < 3; i++) begin
      cyc(32'h0, 0, 0, 6'd0, 0, "R7");
      cyc(32'h20, 0, 0, 6'd0, 0, "R7");
    end
    rd(32'h20, 6'd37, "R7");
    check("R7", rd_data, 32'd4);
    // R8: writes to live and counter addresses ignored, holes read zero
    cyc(32'h20, 1, 0, 6'd2, 32'hFFFF_FFFF, "R8");
    cyc(32'h20, 1, 0, 6'd37, 32'h1234_5678, "R8");
    rd(32'h20, 6'd2, "R8");
    rd(32'h20, 6'd37, "R8");
    check("R8", rd_data, 32'd4);
    rd(32'h20, 6'd7, "R8");
    check("R8", rd_data, 32'd0);
    cyc(32'h20, 0, 0, 6'd0, 0, "R8");
    // R7 wrap on 3-bit counter instance
    do_reset();
    for (int i = 0; i < 9; i++) begin
      cyc(32'h1, 0, 0, 6'd0, 0, "R7");
      cyc(32'h0, 0, 0, 6'd0, 0, "R7");
    end
    rd(32'h0, 6'd32, "R7");
    check("R7", rd_data, 32'd9);
    check("R7", rd_data_w, 32'd1);
    // Random phase
    do_reset();
    irq = '0;
    for (int k = 0; k < 4000; k++) begin
      logic we, re;
      logic [5:0] wa, ra;
      logic [1:0] pick;
      irq = irq ^ ($urandom & $urandom & $urandom);
      we = ($urandom % 4) == 0;
      re = ($urandom % 2) == 0;
      pick = 2'($urandom);
      wa = (pick == 2'd0) ? 6'd0 : (pick == 2'd1) ? 6'd1 :
           (pick == 2'd2) ? 6'd2 : {1'b1, 5'($urandom)};
      ra = 6'($urandom);
      if (($urandom % 3) == 0) ra = 6'($urandom % 3);
      cyc(irq, we, re, we ? wa : ra, $urandom, "");
      if (we) addr = wa;
    end
    for (int i = 0; i < 32; i++) rd(irq, 6'(32 + i), "R7");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule